// File: doc/BRIEF.md
# MOV Instruction Byte-Stream Decoder

This block sits behind an instruction byte queue. It takes one byte per accepted beat and turns the byte sequence of one data-move instruction into one decoded record. A `mode32_i` input gives the default operand and address size for the stream. Size-override prefix bytes flip either default for one instruction only. The decoder works out the instruction length as the bytes arrive, because that length depends on the mode byte, on the effective address size and on the displacement-only encodings. It then reports the operand fields, the index fields, the displacement, the immediate value and the byte count.

Three opcode groups are decoded:

- the register/memory move form, opcodes 88h to 8Bh;
- the immediate-to-memory move, C6h and C7h;
- the segment-register move, 8Ch and 8Eh.

Any other opcode byte ends the instruction at once with an "unsupported" record, and the following byte starts a new instruction. While a record waits for the consumer, the byte input stalls.

Top module: `mov_decoder`

## Requirements
- R1: `in_ready` is 1 exactly when no record is pending. After the last byte of an instruction is accepted, `out_valid` rises on that clock edge, and `in_ready` stays 0 until the record is taken.
- R2: A 66h byte flips the operand size and a 67h byte flips the address size, relative to `mode32_i`, for the current instruction only. The results are reported on `out_op32` and `out_ad32` (1 = 32-bit).
- R3: `out_len` equals the number of bytes consumed by the instruction, prefixes included.
- R4: `out_kind` is 0 for opcodes 88h–8Bh, 1 for C6h/C7h, 2 for 8Ch/8Eh and 3 for any other non-prefix byte. `out_d` is opcode bit 1 and `out_w` is opcode bit 0.
- R5: The byte after the opcode is split as follows: `out_mod` = bits 7:6, `out_reg` = bits 5:3, `out_rm` = bits 2:0.
- R6: An index byte follows the mode byte exactly when the address size is 32, `out_mod` is not 3 and `out_rm` is 4. It is split as follows: `out_scale` = bits 7:6, `out_index` = bits 5:3, `out_base` = bits 2:0, and `out_has_sib` = 1. Without an index byte these four outputs are 0.
- R7: The number of displacement bytes is set by `out_mod`:
  - mod 3 gives 0 bytes and mod 1 gives 1 byte;
  - mod 2 gives 2 bytes with 16-bit addressing and 4 bytes with 32-bit addressing;
  - mod 0 gives 0 bytes, except rm 6 with 16-bit addressing (2 bytes), rm 5 with 32-bit addressing (4 bytes), and an index byte whose base is 5 (4 bytes).
- R8: Displacement bytes arrive low byte first. A one-byte displacement is sign-extended to 32 bits on `out_disp`. Two- and four-byte displacements are zero-extended. With no displacement, `out_disp` is 0.
- R9: For kind 1, an immediate follows the displacement, low byte first. Its length is 1 byte when W is 0, and otherwise 4 or 2 bytes as the operand size is 32 or 16. It is zero-extended onto `out_imm`. For every other kind, `out_imm` is 0.
- R10: An unsupported opcode gives an immediate record with kind 3. Its `out_len` counts the bytes so far, and every field other than kind, sizes and length is 0. The next byte begins a new instruction.
- R11: While `out_valid` is 1 and `out_ready` is 0, the record stays valid and unchanged.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode32_i | input | 1 | Default size: 1 = 32-bit, 0 = 16-bit |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte accepted when high with `in_valid` |
| out_ready | input | 1 | Consumer takes the record |
| out_valid | output | 1 | Record available |
| out_kind | output | 2 | Opcode group (R4) |
| out_op32 | output | 1 | Effective operand size is 32 |
| out_ad32 | output | 1 | Effective address size is 32 |
| out_d | output | 1 | Direction bit |
| out_w | output | 1 | Width bit |
| out_mod | output | 2 | Mode field |
| out_reg | output | 3 | Register field |
| out_rm | output | 3 | Register/memory field |
| out_has_sib | output | 1 | Index byte present |
| out_scale | output | 2 | Scale code |
| out_index | output | 3 | Index register code |
| out_base | output | 3 | Base register code |
| out_disp | output | 32 | Displacement |
| out_imm | output | 32 | Immediate |
| out_len | output | 4 | Instruction length in bytes |

## Verification
The properties assume that each instruction carries each override prefix at most once, which keeps `out_len` at 13 or below. They also assume that `mode32_i` is stable from the first byte of an instruction until its opcode byte is taken. The stimulus sets the mode only between records and adds each prefix with a separate coin flip, never twice. Random traffic varies the gaps between beats and the consumer stall times. Directed cases cover:

- the displacement-only encodings in both address sizes;
- the base-5 index byte;
- a negative one-byte displacement;
- unsupported opcodes, including one that follows a prefix, with resynchronisation on the next byte.

// File: rtl/movdec_pkg.sv
// Package: shared widths, state and record types for the MOV decoder.
// Assumes byte-wide input and at most four displacement/immediate bytes.
package movdec_pkg;
    localparam int BYTE_W     = 8;
    localparam int FIELD_BYTES = 4;
    localparam int WORD_W     = FIELD_BYTES * BYTE_W;
    localparam int CNT_W      = $clog2(FIELD_BYTES);
    localparam int NUM_W      = $clog2(FIELD_BYTES + 1);
    localparam int LEN_W      = 4;
    localparam logic [BYTE_W-1:0] PFX_OPSZ = 8'h66;
    localparam logic [BYTE_W-1:0] PFX_ADSZ = 8'h67;

    typedef enum logic [1:0] {
        K_RM  = 2'd0,
        K_IMM = 2'd1,
        K_SEG = 2'd2,
        K_BAD = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        S_PFX, S_MODRM, S_SIB, S_DISP, S_IMM, S_OUT
    } st_e;

    typedef struct packed {
        kind_e              kind;
        logic               op32;
        logic               ad32;
        logic               d;
        logic               w;
        logic [1:0]         mode;
        logic [2:0]         regf;
        logic [2:0]         rm;
        logic               has_sib;
        logic [1:0]         scale;
        logic [2:0]         idx;
        logic [2:0]         base;
        logic [WORD_W-1:0]  disp;
        logic [WORD_W-1:0]  imm;
        logic [LEN_W-1:0]   len;
    } rec_t;
endpackage

// File: rtl/movdec_opclass.sv
// Module: classifies a leading byte as a size prefix or an opcode group.
// Assumes the byte is in the prefix/opcode position of an instruction.
module movdec_opclass
    import movdec_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output logic              is_opsz_o,
    output logic              is_adsz_o,
    output kind_e             kind_o
);
    assign is_opsz_o = (byte_i == PFX_OPSZ);
    assign is_adsz_o = (byte_i == PFX_ADSZ);

    // Map opcode values onto the supported move groups.
    always_comb begin
        case (byte_i)
            8'h88, 8'h89, 8'h8A, 8'h8B: kind_o = K_RM;
            8'hC6, 8'hC7:               kind_o = K_IMM;
            8'h8C, 8'h8E:               kind_o = K_SEG;
            default:                    kind_o = K_BAD;
        endcase
    end
endmodule

// File: rtl/movdec_fieldlen.sv
// Module: computes index-byte presence and displacement and immediate
// byte counts from mode, rm, base, address size and operand width.
// Assumes base_i is meaningful only when an index byte is present.
module movdec_fieldlen
    import movdec_pkg::*;
(
    input  logic             ad32_i,
    input  logic             op32_i,
    input  kind_e            kind_i,
    input  logic             w_i,
    input  logic [1:0]       mode_i,
    input  logic [2:0]       rm_i,
    input  logic [2:0]       base_i,
    output logic             need_sib_o,
    output logic [NUM_W-1:0] disp_n_o,
    output logic [NUM_W-1:0] imm_n_o
);
    localparam logic [NUM_W-1:0] N_WIDE = NUM_W'(FIELD_BYTES);
    localparam logic [NUM_W-1:0] N_HALF = NUM_W'(FIELD_BYTES / 2);

    assign need_sib_o = ad32_i && (mode_i != 2'd3) && (rm_i == 3'd4);

    // Displacement byte count, including the displacement-only encodings.
    always_comb begin
        case (mode_i)
            2'd1:    disp_n_o = NUM_W'(1);
            2'd2:    disp_n_o = ad32_i ? N_WIDE : N_HALF;
            2'd3:    disp_n_o = '0;
            default: begin
                if (ad32_i)
                    disp_n_o = ((rm_i == 3'd5) || (rm_i == 3'd4 && base_i == 3'd5)) ? N_WIDE : '0;
                else
                    disp_n_o = (rm_i == 3'd6) ? N_HALF : '0;
            end
        endcase
    end

    // Immediate byte count for the immediate-to-memory form.
    always_comb begin
        if (kind_i != K_IMM) imm_n_o = '0;
        else if (!w_i)       imm_n_o = NUM_W'(1);
        else                 imm_n_o = op32_i ? N_WIDE : N_HALF;
    end
endmodule

// File: rtl/mov_decoder.sv
// Module: byte-serial decoder for data-move instructions. It consumes
// prefixes, opcode, mode byte, optional index byte, displacement and
// immediate, and presents one held record per instruction.
// Assumes mode32_i is steady until the opcode byte is accepted.
module mov_decoder
    import movdec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode32_i,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    output logic               in_ready,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [1:0]         out_kind,
    output logic               out_op32,
    output logic               out_ad32,
    output logic               out_d,
    output logic               out_w,
    output logic [1:0]         out_mod,
    output logic [2:0]         out_reg,
    output logic [2:0]         out_rm,
    output logic               out_has_sib,
    output logic [1:0]         out_scale,
    output logic [2:0]         out_index,
    output logic [2:0]         out_base,
    output logic [31:0]        out_disp,
    output logic [31:0]        out_imm,
    output logic [3:0]         out_len
);
    st_e              st;
    rec_t             rec;
    logic             opf, adf;
    logic [CNT_W-1:0] cnt;
    logic [NUM_W-1:0] dn_q;

    logic             is_opsz, is_adsz, need_sib;
    kind_e            cls_kind;
    logic [1:0]       fl_mode;
    logic [2:0]       fl_rm;
    logic [NUM_W-1:0] disp_n, imm_n;

    wire beat = in_valid && in_ready;
    wire [NUM_W-1:0] cnt_ext = NUM_W'(cnt);

    assign in_ready  = (st != S_OUT);
    assign out_valid = (st == S_OUT);

    movdec_opclass u_cls (
        .byte_i    (in_data),
        .is_opsz_o (is_opsz),
        .is_adsz_o (is_adsz),
        .kind_o    (cls_kind)
    );

    // Length logic looks at the incoming mode byte or the stored one.
    assign fl_mode = (st == S_MODRM) ? in_data[7:6] : rec.mode;
    assign fl_rm   = (st == S_MODRM) ? in_data[2:0] : rec.rm;

    movdec_fieldlen u_len (
        .ad32_i     (rec.ad32),
        .op32_i     (rec.op32),
        .kind_i     (rec.kind),
        .w_i        (rec.w),
        .mode_i     (fl_mode),
        .rm_i       (fl_rm),
        .base_i     (in_data[2:0]),
        .need_sib_o (need_sib),
        .disp_n_o   (disp_n),
        .imm_n_o    (imm_n)
    );

    // Byte-by-byte decode state machine and record assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= S_PFX;
            rec  <= '0;
            opf  <= 1'b0;
            adf  <= 1'b0;
            cnt  <= '0;
            dn_q <= '0;
        end else begin
            case (st)
                S_PFX: if (beat) begin
                    rec.len <= rec.len + LEN_W'(1);
                    if (is_opsz)      opf <= 1'b1;
                    else if (is_adsz) adf <= 1'b1;
                    else begin
                        rec.op32 <= mode32_i ^ opf;
                        rec.ad32 <= mode32_i ^ adf;
                        rec.kind <= cls_kind;
                        if (cls_kind == K_BAD) st <= S_OUT;
                        else begin
                            rec.d <= in_data[1];
                            rec.w <= in_data[0];
                            st    <= S_MODRM;
                        end
                    end
                end
                S_MODRM: if (beat) begin
                    rec.len  <= rec.len + LEN_W'(1);
                    rec.mode <= in_data[7:6];
                    rec.regf <= in_data[5:3];
                    rec.rm   <= in_data[2:0];
                    dn_q     <= disp_n;
                    if (need_sib)         st <= S_SIB;
                    else if (disp_n != 0) st <= S_DISP;
                    else if (imm_n != 0)  st <= S_IMM;
                    else                  st <= S_OUT;
                end
                S_SIB: if (beat) begin
                    rec.len     <= rec.len + LEN_W'(1);
                    rec.has_sib <= 1'b1;
                    rec.scale   <= in_data[7:6];
                    rec.idx     <= in_data[5:3];
                    rec.base    <= in_data[2:0];
                    dn_q        <= disp_n;
                    if (disp_n != 0)     st <= S_DISP;
                    else if (imm_n != 0) st <= S_IMM;
                    else                 st <= S_OUT;
                end
                S_DISP: if (beat) begin
                    rec.len <= rec.len + LEN_W'(1);
                    rec.disp[{cnt, 3'b000} +: BYTE_W] <= in_data;
                    cnt <= cnt + CNT_W'(1);
                    if (cnt_ext == dn_q - NUM_W'(1)) begin
                        cnt <= '0;
                        if (dn_q == NUM_W'(1))
                            rec.disp <= {{(WORD_W-BYTE_W){in_data[7]}}, in_data};
                        st <= (imm_n != 0) ? S_IMM : S_OUT;
                    end
                end
                S_IMM: if (beat) begin
                    rec.len <= rec.len + LEN_W'(1);
                    rec.imm[{cnt, 3'b000} +: BYTE_W] <= in_data;
                    cnt <= cnt + CNT_W'(1);
                    if (cnt_ext == imm_n - NUM_W'(1)) begin
                        cnt <= '0;
                        st  <= S_OUT;
                    end
                end
                S_OUT: if (out_ready) begin
                    rec <= '0;
                    opf <= 1'b0;
                    adf <= 1'b0;
                    st  <= S_PFX;
                end
                default: st <= S_PFX;
            endcase
        end
    end

    // Present the held record on the output pins.
    assign out_kind    = rec.kind;
    assign out_op32    = rec.op32;
    assign out_ad32    = rec.ad32;
    assign out_d       = rec.d;
    assign out_w       = rec.w;
    assign out_mod     = rec.mode;
    assign out_reg     = rec.regf;
    assign out_rm      = rec.rm;
    assign out_has_sib = rec.has_sib;
    assign out_scale   = rec.scale;
    assign out_index   = rec.idx;
    assign out_base    = rec.base;
    assign out_disp    = rec.disp;
    assign out_imm     = rec.imm;
    assign out_len     = rec.len;
endmodule

// File: rtl/movdec_chk.sv
// Module: property checker for mov_decoder, attached with bind.
// Assumes at most one of each size prefix per instruction.
module movdec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        out_ready,
    input logic        out_valid,
    input logic [1:0]  out_kind,
    input logic        out_ad32,
    input logic [1:0]  out_mod,
    input logic [2:0]  out_rm,
    input logic        out_has_sib,
    input logic [31:0] out_disp,
    input logic [31:0] out_imm,
    input logic [3:0]  out_len
);
    // R1: input stalls while a record is pending
    a_r1_stall_on_record: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R11: record held while the consumer stalls
    a_r11_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_len)
            && $stable(out_disp) && $stable(out_imm) && $stable(out_kind));

    // R6: index byte only in its addressing context
    a_r6_sib_context: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_has_sib |-> out_ad32 && out_rm == 3'd4 && out_mod != 2'd3);

    // R3: length bounded by the longest legal instruction
    a_r3_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_len != 4'd0 && out_len <= 4'd13);

    // R9: immediate appears only for the immediate form
    a_r9_imm_kind: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind != 2'd1 |-> out_imm == 32'd0);

    // R10: unsupported record carries no operand data
    a_r10_bad_clean: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == 2'd3 |-> !out_has_sib && out_disp == 32'd0 && out_mod == 2'd0);
endmodule

bind mov_decoder movdec_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_kind    (out_kind),
    .out_ad32    (out_ad32),
    .out_mod     (out_mod),
    .out_rm      (out_rm),
    .out_has_sib (out_has_sib),
    .out_disp    (out_disp),
    .out_imm     (out_imm),
    .out_len     (out_len)
);

// File: tb/mov_decoder_tb.sv
// Bench: directed and seeded random instructions, with expected records
// computed by bench functions from the requirements.
module mov_decoder_tb;
    logic clk = 1'b0, rst_n = 1'b0, mode32 = 1'b0;
    logic in_valid = 1'b0, out_ready = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, out_valid, out_op32, out_ad32, out_d, out_w, out_has_sib;
    logic [1:0] out_kind, out_mod, out_scale;
    logic [2:0] out_reg, out_rm, out_index, out_base;
    logic [31:0] out_disp, out_imm;
    logic [3:0] out_len;

    int nchk = 0, nbad = 0, gap_max = 0, hold_max = 0;
    logic [7:0] bq [16];
    int bn;
    logic [1:0] e_kind, e_mod, e_scale;
    logic e_op32, e_ad32, e_d, e_w, e_sib;
    logic [2:0] e_reg, e_rm, e_idx, e_base;
    logic [31:0] e_disp, e_imm;
    int e_len;

    mov_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .mode32_i(mode32), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .out_ready(out_ready),
        .out_valid(out_valid), .out_kind(out_kind), .out_op32(out_op32),
        .out_ad32(out_ad32), .out_d(out_d), .out_w(out_w), .out_mod(out_mod),
        .out_reg(out_reg), .out_rm(out_rm), .out_has_sib(out_has_sib),
        .out_scale(out_scale), .out_index(out_index), .out_base(out_base),
        .out_disp(out_disp), .out_imm(out_imm), .out_len(out_len)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int kind_of(input logic [7:0] o);
        case (o)
            8'h88, 8'h89, 8'h8A, 8'h8B: return 0;
            8'hC6, 8'hC7:               return 1;
            8'h8C, 8'h8E:               return 2;
            default:                    return 3;
        endcase
    endfunction

    // R7 displacement byte count
    function automatic int dcount(input bit a32, input logic [1:0] m,
                                  input logic [2:0] r, input logic [2:0] b);
        if (m == 2'd3) return 0;
        if (m == 2'd1) return 1;
        if (m == 2'd2) return a32 ? 4 : 2;
        if (a32) return (r == 3'd5 || (r == 3'd4 && b == 3'd5)) ? 4 : 0;
        return (r == 3'd6) ? 2 : 0;
    endfunction

    // Build the byte sequence and the expected record of one instruction.
    task automatic gen(input bit m32, input bit pop, input bit pad,
                       input logic [7:0] opc, input logic [7:0] mrm,
                       input logic [7:0] sib, input logic [31:0] dv,
                       input logic [31:0] iv);
        int dn, imn;
        bn = 0;
        mode32 = m32;
        if (pop) begin bq[bn] = 8'h66; bn++; end
        if (pad) begin bq[bn] = 8'h67; bn++; end
        bq[bn] = opc; bn++;
        e_op32 = m32 ^ pop; e_ad32 = m32 ^ pad; e_kind = 2'(kind_of(opc));
        e_d = 0; e_w = 0; e_mod = 0; e_reg = 0; e_rm = 0; e_sib = 0;
        e_scale = 0; e_idx = 0; e_base = 0; e_disp = 0; e_imm = 0;
        if (e_kind == 2'd3) begin e_len = bn; return; end
        e_d = opc[1]; e_w = opc[0];
        bq[bn] = mrm; bn++;
        e_mod = mrm[7:6]; e_reg = mrm[5:3]; e_rm = mrm[2:0];
        e_sib = e_ad32 && e_mod != 2'd3 && e_rm == 3'd4;
        if (e_sib) begin
            bq[bn] = sib; bn++;
            e_scale = sib[7:6]; e_idx = sib[5:3]; e_base = sib[2:0];
        end
        dn = dcount(e_ad32, e_mod, e_rm, e_sib ? sib[2:0] : 3'd0);
        for (int i = 0; i < dn; i++) begin bq[bn] = dv[8*i +: 8]; bn++; end
        if (dn == 1)      e_disp = {{24{dv[7]}}, dv[7:0]};
        else if (dn == 2) e_disp = {16'h0, dv[15:0]};
        else if (dn == 4) e_disp = dv;
        imn = (e_kind != 2'd1) ? 0 : (!opc[0] ? 1 : (e_op32 ? 4 : 2));
        for (int i = 0; i < imn; i++) begin bq[bn] = iv[8*i +: 8]; bn++; end
        if (imn == 1)      e_imm = {24'h0, iv[7:0]};
        else if (imn == 2) e_imm = {16'h0, iv[15:0]};
        else if (imn == 4) e_imm = iv;
        e_len = bn;
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        repeat ($urandom_range(gap_max, 0)) @(negedge clk);
        in_valid = 1'b1; in_data = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    // Send the built instruction and compare the record it produces.
    task automatic run_one();
        int w;
        for (int i = 0; i < bn; i++) put(bq[i]);
        @(negedge clk);
        w = 0;
        while (!out_valid && w < 50) begin @(negedge clk); w++; end
        chk(out_valid == 1'b1, "R1", "record valid", 32'(out_valid), 32'd1);
        chk(in_ready == 1'b0, "R1", "stall while pending", 32'(in_ready), 32'd0);
        chk(out_len == 4'(e_len), "R3", "length", 32'(out_len), 32'(e_len));
        chk(out_kind == e_kind, "R4", "kind", 32'(out_kind), 32'(e_kind));
        chk({out_d, out_w} == {e_d, e_w}, "R4", "d/w", 32'({out_d, out_w}), 32'({e_d, e_w}));
        chk({out_op32, out_ad32} == {e_op32, e_ad32}, "R2", "sizes",
            32'({out_op32, out_ad32}), 32'({e_op32, e_ad32}));
        chk({out_mod, out_reg, out_rm} == {e_mod, e_reg, e_rm}, "R5", "mode byte",
            32'({out_mod, out_reg, out_rm}), 32'({e_mod, e_reg, e_rm}));
        chk({out_has_sib, out_scale, out_index, out_base} == {e_sib, e_scale, e_idx, e_base},
            "R6", "index byte", 32'({out_has_sib, out_scale, out_index, out_base}),
            32'({e_sib, e_scale, e_idx, e_base}));
        chk(out_disp == e_disp, "R8", "displacement (R7 count)", out_disp, e_disp);
        chk(out_imm == e_imm, "R9", "immediate", out_imm, e_imm);
        repeat ($urandom_range(hold_max, 0)) @(negedge clk);
        chk(out_valid && out_len == 4'(e_len) && out_disp == e_disp && out_imm == e_imm,
            "R11", "held record", out_disp, e_disp);
        out_ready = 1'b1;
        @(posedge clk); #1;
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        logic [7:0] opc;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R12", "reset out_valid", 32'(out_valid), 32'd0);
        chk(in_ready == 1'b1, "R12", "reset in_ready", 32'(in_ready), 32'd1);

        // Directed corner cases.
        gen(0, 0, 0, 8'h8B, 8'hEC, 8'h00, 0, 0); run_one();                       // R5 register form
        gen(0, 0, 0, 8'h8A, 8'h95, 8'h00, 32'h1000, 0); run_one();                // R8 16-bit disp
        gen(0, 1, 0, 8'h8B, 8'hE8, 8'h00, 0, 0); run_one();                       // R2 operand flip
        gen(0, 1, 1, 8'h8B, 8'h04, 8'h8B, 0, 0); run_one();                       // R6 index byte
        gen(0, 0, 0, 8'hC7, 8'h87, 8'h00, 32'h1000, 32'h1234); run_one();         // R9 word imm
        gen(0, 0, 0, 8'hC6, 8'h06, 8'h00, 32'h1000, 32'h55); run_one();           // R7 disp-only 16
        gen(1, 0, 0, 8'h8B, 8'h05, 8'h00, 32'h12345678, 0); run_one();            // R7 disp-only 32
        gen(1, 0, 0, 8'h8B, 8'h04, 8'h25, 32'hCAFEF00D, 0); run_one();            // R7 base-5 index
        gen(1, 0, 0, 8'hC7, 8'h40, 8'h00, 32'hF0, 32'hDEADBEEF); run_one();       // R8 sign extension
        gen(1, 1, 0, 8'hC7, 8'hC0, 8'h00, 0, 32'hBEEF); run_one();                // R9 16-bit imm
        gen(0, 0, 0, 8'h8E, 8'hD8, 8'h00, 0, 0); run_one();                       // R4 segment form
        gen(0, 0, 0, 8'h90, 8'h00, 8'h00, 0, 0); run_one();                       // R10 unsupported
        gen(0, 1, 0, 8'hF4, 8'h00, 8'h00, 0, 0); run_one();                       // R10 after prefix
        gen(0, 0, 0, 8'h8B, 8'hEC, 8'h00, 0, 0); run_one();                       // R10 resync, R2 no carry-over

        // Seeded random traffic.
        for (int n = 0; n < 400; n++) begin
            gap_max = (n < 200) ? 0 : 3;
            hold_max = 3;
            if ($urandom_range(19, 0) == 0) begin
                do opc = 8'($urandom);
                while (kind_of(opc) != 3 || opc == 8'h66 || opc == 8'h67);
            end else begin
                case ($urandom_range(7, 0))
                    0: opc = 8'h88; 1: opc = 8'h89; 2: opc = 8'h8A; 3: opc = 8'h8B;
                    4: opc = 8'hC6; 5: opc = 8'hC7; 6: opc = 8'h8C; default: opc = 8'h8E;
                endcase
            end
            gen(1'($urandom), $urandom_range(3, 0) == 0, $urandom_range(3, 0) == 0,
                opc, 8'($urandom), 8'($urandom), $urandom, $urandom);
            run_one();
        end

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule